// File: doc/BRIEF.md
# Adjustable Conversion Period Counter

This block divides the master clock into conversion periods for one converter channel. A 6-bit down-counter is loaded with a programmed period length. It counts down, and when it reaches 1 it emits a one-clock `period_end` pulse and reloads itself on the same edge. The period length is therefore the loaded value in master-clock cycles.

Software can stretch or shorten a single period by posting a signed trim command. The command stays pending until the next reload and is then applied to exactly one period. After that, periods return to the plain programmed length.

Illegal arithmetic results are replaced with safe reload values. An illegal programmed length raises one of two sticky flags. The first stops the counter. The second marks the serial link as unusable. Both flags clear only on reset.

Top module: `conv_period_ctr`

## Requirements
- R1: After reset, `period_end`, `shutdown` and `port_fail` are low, and the programmed period is `DEFAULT_A` (16) cycles, so consecutive `period_end` pulses are 16 cycles apart.
- R2: With no trim pending, pulses on `period_end` are spaced by the programmed length A and each pulse is exactly one clock wide. A write to A (`a_wr`) takes effect at the next reload, so the period already running keeps its old length.
- R3: `adj_delta` is a 6-bit two's-complement trim value, latched by `adj_wr` together with `adj_sub`. With `adj_sub`=0 the trimmed length is A+trim, and with `adj_sub`=1 it is A−trim. The trim is applied at the first reload after the command. A command sampled on the reload cycle itself waits for the following reload.
- R4: A trim affects one period only. Later periods use plain A until a new command arrives.
- R5: A second command that arrives while one is still pending replaces it, and only the newer trim is applied.
- R6: If the trimmed sum equals 0 or 1, the period uses plain A and the trim is dropped.
- R7: If the trimmed sum is negative, 64 is added to it, and the result is used as the period.
- R8: If the trimmed sum exceeds 63, it is reduced modulo 64. If that wrapped value is 0 or 1, plain A is used instead.
- R9: Writing A with 0 or 1 sets `shutdown` on the next cycle. `shutdown` stays set until reset, even if A is rewritten, and no `period_end` pulse occurs while it is set.
- R10: Writing A below 4 with `byte_mode`=0, or below 5 with `byte_mode`=1, sets a sticky `port_fail` flag. This flag clears only on reset, and counting continues while it is set.
- R11: Reset clears both flags and any pending trim command, and restores the default period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Write strobe for the programmed period |
| a_wdata | input | 6 | New programmed period length, unsigned |
| adj_wr | input | 1 | One-shot trim command strobe |
| adj_delta | input | 6 | Signed trim value, two's complement |
| adj_sub | input | 1 | 0: add trim, 1: subtract trim; latched with `adj_wr` |
| byte_mode | input | 1 | Selects the byte-mode serial minimum (5) instead of the word-mode minimum (4) |
| period_end | output | 1 | One-clock pulse at the end of each period |
| shutdown | output | 1 | Sticky flag: an illegal period of 0 or 1 was programmed |
| port_fail | output | 1 | Sticky flag: the period is too short for serial transfers |

## Verification
The following are checked as properties on every cycle:
- the counter steps down by one between reloads;
- each reload takes the computed value, and that value is never 0 or 1 while A is legal;
- pulses are single-cycle;
- a command always becomes pending and a reload without a new command clears it;
- both flags are entered on the right writes, never drop, and a stopped counter emits no pulse.

The bench scenarios are needed for the arithmetic itself: the exact trimmed lengths, negative and positive wraparound with the 0/1 fallback, deferral of a command that lands on the reload cycle, replacement of a pending trim, and the return to plain A one period later.

// File: rtl/cpc_pkg.sv
`timescale 1ns/1ps
package cpc_pkg;
    // counter width; the wraparound rule is modulo 2**CNT_W
    localparam int unsigned CNT_W = 6;
    // headroom for sign and carry of base +/- trim
    localparam int unsigned SUM_W = CNT_W + 2;

    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic signed [CNT_W-1:0] delta_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef enum logic {
        ADJ_ADD = 1'b0,
        ADJ_SUB = 1'b1
    } adj_op_e;

    typedef struct packed {
        logic    valid;
        adj_op_e op;
        delta_t  delta;
    } adj_cmd_t;

    typedef struct packed {
        logic shutdown;
        logic port_fail;
    } guard_flags_t;

    // signed base +/- trim, evaluated without loss
    function automatic sum_t trim_sum(input cnt_t base, input adj_cmd_t cmd);
        sum_t b;
        sum_t d;
        b = sum_t'({{(SUM_W-CNT_W){1'b0}}, base});
        d = sum_t'({{(SUM_W-CNT_W){cmd.delta[CNT_W-1]}}, cmd.delta});
        return (cmd.op == ADJ_SUB) ? (b - d) : (b + d);
    endfunction

    // a count of 0 or 1 can never be a usable period
    function automatic logic too_short(input cnt_t v);
        return v < cnt_t'(2);
    endfunction

    // next reload value: plain base, or the trimmed value folded into range
    function automatic cnt_t fold_reload(input cnt_t base, input adj_cmd_t cmd);
        sum_t s;
        cnt_t w;
        if (!cmd.valid) begin
            return base;
        end
        s = trim_sum(base, cmd);
        if (s == sum_t'(0) || s == sum_t'(1)) begin
            return base;
        end
        // low bits give +64 for negatives and -64 for overflow
        w = s[CNT_W-1:0];
        if (too_short(w)) begin
            return base;
        end
        return w;
    endfunction
endpackage

// File: rtl/cpc_guard.sv
`timescale 1ns/1ps
module cpc_guard
    import cpc_pkg::*;
#(
    parameter int unsigned DEFAULT_A = 16,
    parameter int unsigned WORD_MIN  = 4,
    parameter int unsigned BYTE_MIN  = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         a_wr,
    input  cnt_t         a_wdata,
    input  logic         byte_mode,
    output cnt_t         a_q,
    output guard_flags_t flags
);
    localparam cnt_t RESET_A  = cnt_t'(DEFAULT_A);
    localparam cnt_t WORD_LIM = cnt_t'(WORD_MIN);
    localparam cnt_t BYTE_LIM = cnt_t'(BYTE_MIN);

    cnt_t serial_lim;

    always_comb begin
        serial_lim = byte_mode ? BYTE_LIM : WORD_LIM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= RESET_A;
            flags <= '0;
        end else if (a_wr) begin
            a_q <= a_wdata;
            if (too_short(a_wdata)) begin
                flags.shutdown <= 1'b1;
            end
            if (a_wdata < serial_lim) begin
                flags.port_fail <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpc_adj_hold.sv
`timescale 1ns/1ps
module cpc_adj_hold
    import cpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adj_wr,
    input  delta_t   adj_delta,
    input  logic     adj_sub,
    input  logic     consume,
    output adj_cmd_t cmd
);
    adj_cmd_t incoming;

    always_comb begin
        incoming.valid = 1'b1;
        incoming.op    = adj_sub ? ADJ_SUB : ADJ_ADD;
        incoming.delta = adj_delta;
    end

    // a new command wins over the clear at a reload
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (adj_wr) begin
            cmd <= incoming;
        end else if (consume) begin
            cmd.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cpc_reload_calc.sv
`timescale 1ns/1ps
module cpc_reload_calc
    import cpc_pkg::*;
(
    input  cnt_t     a_q,
    input  adj_cmd_t cmd,
    output cnt_t     reload_val
);
    always_comb begin
        reload_val = fold_reload(a_q, cmd);
    end
endmodule

// File: rtl/cpc_down_cnt.sv
`timescale 1ns/1ps
module cpc_down_cnt
    import cpc_pkg::*;
#(
    parameter int unsigned DEFAULT_A = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    input  cnt_t reload_val,
    output cnt_t cnt_q,
    output logic tick
);
    localparam cnt_t RESET_CNT = cnt_t'(DEFAULT_A);
    localparam cnt_t LAST_CNT  = cnt_t'(1);

    always_comb begin
        tick = !halt && (cnt_q == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RESET_CNT;
        end else if (!halt) begin
            if (tick) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q - LAST_CNT;
            end
        end
    end
endmodule

// File: rtl/conv_period_ctr.sv
`timescale 1ns/1ps
module conv_period_ctr
    import cpc_pkg::*;
#(
    parameter int unsigned DEFAULT_A = 16,
    parameter int unsigned WORD_MIN  = 4,
    parameter int unsigned BYTE_MIN  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_wr,
    input  logic [CNT_W-1:0] a_wdata,
    input  logic             adj_wr,
    input  logic [CNT_W-1:0] adj_delta,
    input  logic             adj_sub,
    input  logic             byte_mode,
    output logic             period_end,
    output logic             shutdown,
    output logic             port_fail
);
    cnt_t         a_q;
    guard_flags_t flags;
    adj_cmd_t     adj_cmd;
    cnt_t         reload_val;
    cnt_t         cnt_q;
    logic         tick;

    cpc_guard #(
        .DEFAULT_A (DEFAULT_A),
        .WORD_MIN  (WORD_MIN),
        .BYTE_MIN  (BYTE_MIN)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .a_wr      (a_wr),
        .a_wdata   (a_wdata),
        .byte_mode (byte_mode),
        .a_q       (a_q),
        .flags     (flags)
    );

    cpc_adj_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .adj_wr    (adj_wr),
        .adj_delta (delta_t'(adj_delta)),
        .adj_sub   (adj_sub),
        .consume   (tick),
        .cmd       (adj_cmd)
    );

    cpc_reload_calc u_calc (
        .a_q        (a_q),
        .cmd        (adj_cmd),
        .reload_val (reload_val)
    );

    cpc_down_cnt #(
        .DEFAULT_A (DEFAULT_A)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .halt       (flags.shutdown),
        .reload_val (reload_val),
        .cnt_q      (cnt_q),
        .tick       (tick)
    );

    always_comb begin
        period_end = tick;
        shutdown   = flags.shutdown;
        port_fail  = flags.port_fail;
    end
endmodule

// File: rtl/cpc_checker.sv
`timescale 1ns/1ps
module cpc_checker
    import cpc_pkg::*;
#(
    parameter int unsigned WORD_MIN = 4,
    parameter int unsigned BYTE_MIN = 5
) (
    input logic clk,
    input logic rst,
    input logic a_wr,
    input cnt_t a_wdata,
    input logic adj_wr,
    input logic byte_mode,
    input logic period_end,
    input logic shutdown,
    input logic port_fail,
    input cnt_t cnt_q,
    input cnt_t reload_val,
    input logic adj_pend,
    input cnt_t a_q
);
    a_r2_reload_value: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (cnt_q == $past(reload_val)));

    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        (!period_end && !shutdown) |=> (cnt_q == $past(cnt_q) - cnt_t'(1)));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end);

    a_r3_cmd_latched: assert property (@(posedge clk) disable iff (rst)
        adj_wr |=> adj_pend);

    a_r4_pending_cleared: assert property (@(posedge clk) disable iff (rst)
        (period_end && !adj_wr) |=> !adj_pend);

    a_r6_reload_legal: assert property (@(posedge clk) disable iff (rst)
        (a_q >= cnt_t'(2)) |-> (reload_val >= cnt_t'(2)));

    a_r9_enter: assert property (@(posedge clk) disable iff (rst)
        (a_wr && a_wdata < cnt_t'(2)) |=> shutdown);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> shutdown);

    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> !period_end);

    a_r10_enter_word: assert property (@(posedge clk) disable iff (rst)
        (a_wr && !byte_mode && a_wdata < cnt_t'(WORD_MIN)) |=> port_fail);

    a_r10_enter_byte: assert property (@(posedge clk) disable iff (rst)
        (a_wr && byte_mode && a_wdata < cnt_t'(BYTE_MIN)) |=> port_fail);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        port_fail |=> port_fail);
endmodule

bind conv_period_ctr cpc_checker #(
    .WORD_MIN (WORD_MIN),
    .BYTE_MIN (BYTE_MIN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_wr       (a_wr),
    .a_wdata    (a_wdata),
    .adj_wr     (adj_wr),
    .byte_mode  (byte_mode),
    .period_end (period_end),
    .shutdown   (shutdown),
    .port_fail  (port_fail),
    .cnt_q      (cnt_q),
    .reload_val (reload_val),
    .adj_pend   (adj_cmd.valid),
    .a_q        (a_q)
);

// File: tb/sim_conv_period_ctr.sv
`timescale 1ns/1ps
module sim_conv_period_ctr;
    import cpc_pkg::*;

    localparam int DEF_A = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_wr = 1'b0;
    logic adj_wr = 1'b0;
    logic adj_sub = 1'b0;
    logic byte_mode = 1'b0;
    logic [CNT_W-1:0] a_wdata = '0;
    logic [CNT_W-1:0] adj_delta = '0;
    logic period_end;
    logic shutdown;
    logic port_fail;

    always #4 clk = ~clk;

    conv_period_ctr #(
        .DEFAULT_A (DEF_A),
        .WORD_MIN  (4),
        .BYTE_MIN  (5)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .a_wr       (a_wr),
        .a_wdata    (a_wdata),
        .adj_wr     (adj_wr),
        .adj_delta  (adj_delta),
        .adj_sub    (adj_sub),
        .byte_mode  (byte_mode),
        .period_end (period_end),
        .shutdown   (shutdown),
        .port_fail  (port_fail)
    );

    typedef struct {
        int    len;
        string tag;
    } exp_t;

    exp_t expq[$];
    exp_t e;
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   last_cyc = 0;
    bit   have_last = 0;
    int   pulse_cnt = 0;
    bit   prev_pe = 0;
    int   cur_a = DEF_A;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // model of the period rules, written from the requirements
    function automatic int exp_reload(input int a, input int d, input bit sub);
        int s;
        s = sub ? (a - d) : (a + d);
        if (s == 0 || s == 1) return a;    // R6
        if (s < 0) s = s + 64;              // R7
        else if (s > 63) s = s - 64;        // R8
        if (s == 0 || s == 1) return a;     // R8 wrapped fallback
        return s;
    endfunction

    // monitor: measures pulse spacing and pops expected lengths
    always @(negedge clk) begin
        cyc++;
        if (period_end === 1'b1) begin
            check(prev_pe == 1'b0, "R2 pulse one clock wide", int'(prev_pe), 0);
            pulse_cnt++;
            if (have_last && expq.size() > 0) begin
                e = expq.pop_front();
                check((cyc - last_cyc) == e.len, e.tag, cyc - last_cyc, e.len);
            end
            last_cyc  = cyc;
            have_last = 1'b1;
        end
        prev_pe = (period_end === 1'b1);
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sync();
        int n0;
        expq.delete();
        have_last = 1'b0;
        n0 = pulse_cnt;
        while (pulse_cnt == n0) step();
    endtask

    task automatic push(input int len, input string tag);
        exp_t x;
        x.len = len;
        x.tag = tag;
        expq.push_back(x);
    endtask

    task automatic wait_pulses(input int n);
        int n0;
        n0 = pulse_cnt;
        while (pulse_cnt < n0 + n) step();
    endtask

    task automatic drain(input string tag);
        check(expq.size() == 0, tag, expq.size(), 0);
    endtask

    task automatic drive_a(input int v);
        a_wr    = 1'b1;
        a_wdata = CNT_W'(v);
        step();
        a_wr    = 1'b0;
    endtask

    task automatic drive_adj(input int d, input bit sub);
        adj_wr    = 1'b1;
        adj_delta = CNT_W'(d);
        adj_sub   = sub;
        step();
        adj_wr    = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        cur_a = DEF_A;
    endtask

    // one trimmed period between two plain ones
    task automatic adj_case(input int d, input bit sub, input string tag);
        sync();
        push(cur_a, {tag, " period before trim"});
        drive_adj(d, sub);
        push(exp_reload(cur_a, d, sub), tag);
        push(cur_a, "R4 plain period after trim");
        wait_pulses(3);
        drain({tag, " all periods seen"});
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        check(period_end == 1'b0, "R1 period_end low after reset", int'(period_end), 0);
        check(shutdown == 1'b0, "R1 shutdown low after reset", int'(shutdown), 0);
        check(port_fail == 1'b0, "R1 port_fail low after reset", int'(port_fail), 0);
        sync();
        push(DEF_A, "R1 default period");
        push(DEF_A, "R1 default period");
        wait_pulses(2);
        drain("R1 all periods seen");

        // R2 new A takes effect at the next reload
        sync();
        push(DEF_A, "R2 running period keeps old length");
        drive_a(9);
        cur_a = 9;
        push(9, "R2 new period length");
        push(9, "R2 new period length");
        wait_pulses(3);
        drain("R2 all periods seen");

        // R3 add and subtract, R4 single shot
        adj_case(5, 1'b0, "R3 add trim 9+5");
        adj_case(-3, 1'b1, "R3 subtract negative trim 9-(-3)");

        // R3 command on the reload cycle waits one reload
        sync();
        repeat (cur_a - 1) step();
        push(cur_a, "R3 period before deferred trim");
        drive_adj(4, 1'b0);
        push(cur_a, "R3 reload-cycle command not applied yet");
        push(13, "R3 deferred trim applied");
        push(cur_a, "R4 plain period after deferred trim");
        wait_pulses(4);
        drain("R3 deferred all periods seen");

        // R5 replacement of a pending command
        sync();
        push(cur_a, "R5 period before trims");
        drive_adj(10, 1'b0);
        drive_adj(-4, 1'b0);
        push(5, "R5 newer trim replaces older");
        push(cur_a, "R4 plain after replaced trim");
        wait_pulses(3);
        drain("R5 all periods seen");

        // R6 degenerate sums
        adj_case(-8, 1'b0, "R6 sum 1 falls back to A");
        adj_case(9, 1'b1, "R6 sum 0 falls back to A");

        // R7 negative wrap
        adj_case(-20, 1'b0, "R7 negative sum plus 64");
        adj_case(25, 1'b1, "R7 negative difference plus 64");

        // R8 overflow wrap
        sync();
        drive_a(40);
        cur_a = 40;
        wait_pulses(2);
        adj_case(-30, 1'b1, "R8 overflow 70 wraps to 6");
        adj_case(-24, 1'b1, "R8 wrap to 0 falls back to A");
        adj_case(-25, 1'b1, "R8 wrap to 1 falls back to A");

        // R11 reset drops a pending trim
        sync();
        drive_adj(5, 1'b0);
        do_reset();
        sync();
        push(DEF_A, "R11 pending trim dropped by reset");
        push(DEF_A, "R11 default period restored");
        wait_pulses(2);
        drain("R11 all periods seen");

        // R10 word mode limits
        byte_mode = 1'b0;
        drive_a(4);
        check(port_fail == 1'b0, "R10 word mode A=4 accepted", int'(port_fail), 0);
        drive_a(3);
        check(port_fail == 1'b1, "R10 word mode A=3 flags port", int'(port_fail), 1);
        check(shutdown == 1'b0, "R10 A=3 does not stop counter", int'(shutdown), 0);
        cur_a = 3;
        wait_pulses(1);
        sync();
        push(3, "R10 counting continues with port fault");
        push(3, "R10 counting continues with port fault");
        wait_pulses(2);
        drain("R10 all periods seen");
        drive_a(9);
        step();
        check(port_fail == 1'b1, "R10 port_fail sticky", int'(port_fail), 1);
        do_reset();
        check(port_fail == 1'b0, "R11 reset clears port_fail", int'(port_fail), 0);

        // R10 byte mode limits
        byte_mode = 1'b1;
        drive_a(5);
        check(port_fail == 1'b0, "R10 byte mode A=5 accepted", int'(port_fail), 0);
        drive_a(4);
        check(port_fail == 1'b1, "R10 byte mode A=4 flags port", int'(port_fail), 1);
        do_reset();
        byte_mode = 1'b0;

        // R9 shutdown
        begin
            int n0;
            drive_a(1);
            check(shutdown == 1'b1, "R9 A=1 sets shutdown", int'(shutdown), 1);
            check(port_fail == 1'b1, "R10 A=1 also below serial minimum", int'(port_fail), 1);
            n0 = pulse_cnt;
            repeat (40) step();
            check(pulse_cnt == n0, "R9 no pulses in shutdown", pulse_cnt - n0, 0);
            drive_a(20);
            repeat (30) step();
            check(shutdown == 1'b1, "R9 shutdown sticky after rewrite", int'(shutdown), 1);
            check(pulse_cnt == n0, "R9 still no pulses after rewrite", pulse_cnt - n0, 0);
            do_reset();
            check(shutdown == 1'b0, "R11 reset clears shutdown", int'(shutdown), 0);
            drive_a(0);
            check(shutdown == 1'b1, "R9 A=0 sets shutdown", int'(shutdown), 1);
            do_reset();
        end
        sync();
        push(DEF_A, "R11 default period after shutdown");
        push(DEF_A, "R11 default period after shutdown");
        wait_pulses(2);
        drain("R11 all periods seen after shutdown");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule